// File: doc/BRIEF.md
# Bulk program-and-verify flash sequencer

This block runs a streamed bulk-programming session against a small word-addressed flash array model that it holds inside. A session has two passes. In the program pass each accepted bus write stores one word. Storing uses flash rules, so a bit can only be cleared. In the verify pass the same words are sent again in the same order. Each one is compared with the stored word. A location that differs is programmed again when clearing bits is enough to fix it. Otherwise a sticky error bit is raised.

Each pass is closed in-band. The closing write carries an all-ones data word and an address outside the block that holds the pass's first address. A pass of n words therefore needs n+1 writes. The status output shows whether the block can accept the next word, whether the controller is idle, and whether an uncorrectable location was found. A separate combinational read port lets the surrounding logic inspect the array.

Top module: `bulk_prog_seq`

## Requirements
- R1: After reset, status_o reads 0x80. Bit 7 is idle (1 = idle), bit 4 is error and bit 0 is busy (1 = busy). Every array word reads all ones. Writes made while idle change neither the array nor the status.
- R2: `start_i` opens a program pass. The first accepted write latches the start address and programs its data to that address. A program always stores old AND data.
- R3: A later write whose address equals the start address targets the internal next address, which is the previous target + 1. A write to any other address in the same block (same address bits above BLK_AW) targets that address, and the writes after it continue from there.
- R4: Each program or reprogram holds status bit 0 at 1 for exactly PROG_CYC cycles. A write that arrives while bit 0 is 1 is ignored.
- R5: During a pass, a write outside the start block is ignored unless its data is all ones. An all-ones write outside the start block ends the program pass without touching the array and opens the verify pass, with bit 7 still 0.
- R6: In the verify pass, a word equal to the stored contents of its target holds busy for 1 cycle and leaves the array unchanged.
- R7: A verify word that differs from the stored word but can be reached by clearing bits is reprogrammed. The location then holds the verify word, and busy lasts PROG_CYC cycles.
- R8: A verify word that needs any 0-to-1 change sets status bit 4. That location is left unchanged, and bit 4 stays set until the next `start_i`.
- R9: The verify-pass terminator returns the controller to idle (bit 7 = 1) and keeps bit 4. `start_i` clears bit 4 and starts a new session.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a new session (program pass) |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | ADDR_W | Bus write word address |
| wr_data_i | input | DATA_W | Bus write data |
| rd_addr_i | input | ADDR_W | Array read address |
| rd_data_o | output | DATA_W | Array read data (combinational) |
| status_o | output | 8 | Status: bit 7 idle, bit 4 error, bit 0 busy |

## Verification
The bench builds the block with 16-word blocks (BLK_AW = 4), four blocks, 16-bit data and PROG_CYC = 4. The small blocks make the block boundary and the out-of-block terminator cheap to reach. They also let every touched location be read back directly. With a short busy window, the bench can count busy cycles exactly and drop a write into the middle of that window.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_PFIRST,
    S_PRUN,
    S_VFIRST,
    S_VRUN
  } bps_state_e;
endpackage

// File: rtl/bps_array.sv
module bps_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] a_addr_i,
  output logic [DATA_W-1:0] a_data_o,
  input  logic [ADDR_W-1:0] b_addr_i,
  output logic [DATA_W-1:0] b_data_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (we_i) begin
      // flash rule: bits only clear
      mem_q[waddr_i] <= mem_q[waddr_i] & wdata_i;
    end
  end

  assign a_data_o = mem_q[a_addr_i];
  assign b_data_o = mem_q[b_addr_i];

  assert_bits_clear_only_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> ((mem_q[$past(waddr_i)] & ~$past(wdata_i)) == '0));
endmodule

// File: rtl/bps_busy_timer.sv
module bps_busy_timer #(
  parameter int CW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] len_i,
  output logic          busy_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  assert_load_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && len_i != '0) |=> busy_o);
  assert_busy_drains_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !busy_o) |=> !busy_o);
endmodule

// File: rtl/bps_addr_gen.sv
module bps_addr_gen #(
  parameter int ADDR_W = 11,
  parameter int BLK_AW = 10
) (
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic              first_i,
  output logic              in_blk_o,
  output logic [ADDR_W-1:0] tgt_o,
  output logic [ADDR_W-1:0] tgt_inc_o
);
  assign in_blk_o = (wr_addr_i[ADDR_W-1:BLK_AW] == start_addr_i[ADDR_W-1:BLK_AW]);

  always_comb begin
    if (first_i || wr_addr_i != start_addr_i) tgt_o = wr_addr_i;
    else                                      tgt_o = next_addr_i;
  end

  // offset wraps inside the block
  assign tgt_inc_o = {tgt_o[ADDR_W-1:BLK_AW], tgt_o[BLK_AW-1:0] + 1'b1};
endmodule

// File: rtl/bulk_prog_seq.sv
module bulk_prog_seq
  import bps_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int BLK_AW   = 10,
  parameter int NUM_BLK  = 2,
  parameter int PROG_CYC = 4,
  localparam int ADDR_W  = BLK_AW + $clog2(NUM_BLK),
  localparam int CW      = $clog2(PROG_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [7:0]        status_o
);
  bps_state_e        state_q, state_d;
  logic [ADDR_W-1:0] start_q, next_q, tgt, tgt_inc;
  logic              err_q, busy, in_blk;
  logic              first, vfy, acc, term, word;
  logic              mism, fixable, mem_we, load;
  logic [CW-1:0]     len;
  logic [DATA_W-1:0] cur;

  assign first = (state_q == S_PFIRST) || (state_q == S_VFIRST);
  assign vfy   = (state_q == S_VFIRST) || (state_q == S_VRUN);
  assign acc   = wr_en_i && !busy && (state_q != S_IDLE) && !start_i;
  assign term  = acc && !first && !in_blk && (wr_data_i == '1);
  assign word  = acc && (first || in_blk);

  bps_addr_gen #(.ADDR_W(ADDR_W), .BLK_AW(BLK_AW)) u_addr (
    .wr_addr_i   (wr_addr_i),
    .start_addr_i(start_q),
    .next_addr_i (next_q),
    .first_i     (first),
    .in_blk_o    (in_blk),
    .tgt_o       (tgt),
    .tgt_inc_o   (tgt_inc)
  );

  assign mism    = (cur != wr_data_i);
  assign fixable = ((cur & wr_data_i) == wr_data_i);
  assign mem_we  = word && (!vfy || (mism && fixable));
  assign load    = word;
  assign len     = (vfy && !mism) ? CW'(1) : CW'(PROG_CYC);

  bps_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .waddr_i (tgt),
    .wdata_i (wr_data_i),
    .a_addr_i(tgt),
    .a_data_o(cur),
    .b_addr_i(rd_addr_i),
    .b_data_o(rd_data_o)
  );

  bps_busy_timer #(.CW(CW)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .len_i (len),
    .busy_o(busy)
  );

  always_comb begin
    state_d = state_q;
    if (start_i) state_d = S_PFIRST;
    else if (word) begin
      if (state_q == S_PFIRST)      state_d = S_PRUN;
      else if (state_q == S_VFIRST) state_d = S_VRUN;
    end else if (term) begin
      if (state_q == S_PRUN)        state_d = S_VFIRST;
      else if (state_q == S_VRUN)   state_d = S_IDLE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      start_q <= '0;
      next_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_i) err_q <= 1'b0;
      else if (word && vfy && mism && !fixable) err_q <= 1'b1;
      if (word) begin
        next_q <= tgt_inc;
        if (first) start_q <= wr_addr_i;
      end
    end
  end

  assign status_o = {(state_q == S_IDLE) && !busy, 2'b00, err_q, 3'b000, busy};

  assert_idle_no_write_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE) |-> !mem_we);
  assert_no_accept_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !mem_we);
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !start_i) |=> err_q);
  assert_term_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (term && state_q == S_VRUN) |=> status_o[7]);
  assert_term_no_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term |-> !mem_we);
endmodule

// File: tb/bulk_prog_seq_tb_top.sv
module bulk_prog_seq_tb_top;
  localparam int DW = 16;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [7:0]    status;
  int            n_run = 0, n_fail = 0;
  bit            done = 0;

  always #10 clk = ~clk;

  bulk_prog_seq #(.DATA_W(DW), .BLK_AW(4), .NUM_BLK(4), .PROG_CYC(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .status_o(status)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  // waits for ready, writes one word, returns at the negedge after the capture edge
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    while (status[0]) @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (status[0]) begin n++; @(negedge clk); end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset status", status, 8'h80);
    rd_chk("R1 reset array lo", 0, 16'hFFFF);
    rd_chk("R1 reset array hi", 63, 16'hFFFF);
    wr(5, 16'h0000);
    rd_chk("R1 idle write ignored", 5, 16'hFFFF);
    check("R1 idle status", status, 8'h80);
  endtask

  task automatic t_program_verify();
    int n;
    pulse_start();
    wr(16, 16'h1234);
    check("R4 busy during program", status[0], 1'b1);
    // write while busy: must be dropped
    wr_en = 1'b1; wr_addr = 25; wr_data = 16'h0000;
    @(negedge clk); wr_en = 1'b0;
    busy_len(n);
    check("R4 program busy cycles", n + 1, 4);
    wr(16, 16'hABCD);
    wr(16, 16'h5A5A);
    wr(22, 16'h0F0F);
    wr(16, 16'h3C3C);
    wr(40, 16'h0000);
    while (status[0]) @(negedge clk);
    rd_chk("R5 out-of-block data ignored", 40, 16'hFFFF);
    check("R5 still in session", status[7], 1'b0);
    wr(40, 16'hFFFF);
    check("R5 program terminator", status, 8'h00);
    rd_chk("R2 first word", 16, 16'h1234);
    rd_chk("R3 auto increment", 17, 16'hABCD);
    rd_chk("R3 auto increment 2", 18, 16'h5A5A);
    rd_chk("R3 jump", 22, 16'h0F0F);
    rd_chk("R3 continue after jump", 23, 16'h3C3C);
    rd_chk("R3 skipped untouched", 19, 16'hFFFF);
    rd_chk("R4 busy write ignored", 25, 16'hFFFF);
    wr(16, 16'h1234);
    busy_len(n);
    check("R6 compare busy cycles", n, 1);
    wr(16, 16'hABCD);
    wr(18, 16'h5A5A);
    wr(22, 16'h0F0F);
    wr(16, 16'h3C3C);
    wr(0, 16'hFFFF);
    check("R9 verify end idle", status, 8'h80);
    rd_chk("R6 array unchanged", 23, 16'h3C3C);
  endtask

  task automatic t_reprogram_error();
    int n;
    pulse_start();
    wr(32, 16'h0FFF);
    wr(32, 16'h00F0);
    wr(0, 16'hFFFF);
    wr(32, 16'h00FF);
    busy_len(n);
    check("R7 reprogram busy cycles", n, 4);
    rd_chk("R7 reprogrammed", 32, 16'h00FF);
    check("R7 no error", status[4], 1'b0);
    wr(32, 16'h0FF0);
    while (status[0]) @(negedge clk);
    check("R8 error set", status[4], 1'b1);
    rd_chk("R8 location unchanged", 33, 16'h00F0);
    wr(63, 16'hFFFF);
    check("R9 end keeps error", status, 8'h90);
  endtask

  task automatic t_restart();
    pulse_start();
    check("R9 start clears error", status, 8'h00);
    wr(48, 16'hFF00);
    wr(50, 16'hF0F0);
    wr(50, 16'h0FF0);
    while (status[0]) @(negedge clk);
    rd_chk("R2 and-store on erased", 48, 16'hFF00);
    rd_chk("R2 and-store on programmed", 50, 16'h00F0);
    wr(0, 16'hFFFF);
    wr(48, 16'hFF00);
    wr(50, 16'h00F0);
    wr(0, 16'hFFFF);
    check("R9 clean session end", status, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_program_verify();
    t_reprogram_error();
    t_restart();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule